// File: doc/BRIEF.md
# Dual H-Bridge Command Decoder

This block sits between a controller's logic-level motor commands and the gate drivers of two H-bridges. For every half-bridge output it produces two gate enables, one for the high-side switch and one for the low-side switch. The output drives high, drives low, or floats with both switches off. A single mode input picks the command scheme for both bridges. In direct mode the two command bits of a bridge set its two outputs. In direction/enable mode the first bit sets the rotation direction and the second bit gates it. PWM is applied by toggling the command inputs, and the decoder follows every edge.

All command inputs, including the mode input, pass through a two-flop synchronizer before they are decoded. A per-bridge fault input from the protection supervisor floats that bridge at once. The active-low sleep/reset input clears every gate enable asynchronously. Whenever a half-bridge switches on, from either off or the opposite side, its output must first have been off for `DEAD_CYCLES` consecutive cycles. After a long off period, such as coast, a fault or reset, the output can therefore turn on without any extra delay.

Top module: `hbridge_cmd_decoder`

## Requirements
- R1: With `mode` low, bridge b decodes its command pair (`cmd1[b]`, `cmd2[b]`) as follows. 00 leaves both outputs off (coast). 10 drives out1 high and out2 low. 01 drives out1 low and out2 high. 11 drives both outputs low (brake).
- R2: With `mode` high and `cmd2[b]` (enable) low, both outputs of bridge b are driven low, whatever the value of `cmd1[b]` (direction).
- R3: With `mode` high and `cmd2[b]` high, `cmd1[b]` = 0 drives out1 high and out2 low. `cmd1[b]` = 1 drives out1 low and out2 high.
- R4: Each bridge decodes only its own command bits and its own fault input. A change on one bridge leaves the other bridge's enables unchanged.
- R5: On the first rising edge at which `fault[b]` is high, all four enables of bridge b go low. They stay low for as long as the fault is held.
- R6: While `rst_n` is low, every enable is low, without waiting for a clock edge.
- R7: The high and low enables of the same half-bridge are never high together.
- R8: A half-bridge turns on only after it has been off for at least `DEAD_CYCLES` consecutive cycles. When it moves from one side to the other, both enables are low for exactly `DEAD_CYCLES` cycles.
- R9: A command change that is stable before rising edge k appears at the enables after edge k+2: two synchronizer stages and the enable register.
- R10: A half-bridge that has been off for at least `DEAD_CYCLES` cycles (coast, fault or reset) turns on with only the R9 latency. When a fault clears, the outputs return on the next edge.
- Index map: `hi_en[2b]`/`lo_en[2b]` control out1 of bridge b, and `hi_en[2b+1]`/`lo_en[2b+1]` control out2. Bridge A is b = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low sleep/reset, asynchronous assert |
| mode | input | 1 | 0 = direct command bits, 1 = direction/enable |
| cmd1 | input | BRIDGES | Per bridge: out1 command, or direction |
| cmd2 | input | BRIDGES | Per bridge: out2 command, or enable |
| fault | input | BRIDGES | Per bridge: supervisor disable, floats the bridge |
| hi_en | output | 2*BRIDGES | High-side gate enables |
| lo_en | output | 2*BRIDGES | Low-side gate enables |

## Verification
A command change is due three rising edges after it is driven. The bench drives every command on a falling edge and samples on the falling edge after the third rising edge. For a pure turn-on from off, it also confirms that the old value is still present one edge earlier. When a half-bridge switches sides, it must be off at that third edge, still off `DEAD_CYCLES`-1 edges later, and on one edge after that, so the length of the gap is pinned from both sides. Fault effects are checked one edge after the fault is raised or cleared. Reset effects are checked one time unit after `rst_n` falls, without waiting for a clock edge.

// File: rtl/hbridge_cmd_decoder.sv
module hbridge_cmd_decoder #(
  parameter int BRIDGES     = 2,
  parameter int DEAD_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode,
  input  logic [BRIDGES-1:0]   cmd1,
  input  logic [BRIDGES-1:0]   cmd2,
  input  logic [BRIDGES-1:0]   fault,
  output logic [2*BRIDGES-1:0] hi_en,
  output logic [2*BRIDGES-1:0] lo_en
);

  localparam int HALVES = 2 * BRIDGES;
  localparam int SW     = 2 * BRIDGES + 1;
  localparam int GW     = $clog2(DEAD_CYCLES + 1);

  logic [SW-1:0] sync1, sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {mode, cmd2, cmd1};
      sync2 <= sync1;
    end
  end

  logic                 m_s;
  logic [BRIDGES-1:0]   c1_s, c2_s;
  logic [HALVES-1:0]    want_hi, want_lo;

  assign c1_s = sync2[BRIDGES-1:0];
  assign c2_s = sync2[2*BRIDGES-1:BRIDGES];
  assign m_s  = sync2[SW-1];

  for (genvar b = 0; b < BRIDGES; b++) begin : g_dec
    wire en = ~fault[b];
    wire i1 = c1_s[b];
    wire i2 = c2_s[b];
    assign want_hi[2*b]   = en & (m_s ? (i2 & ~i1)  : (i1 & ~i2));
    assign want_lo[2*b]   = en & (m_s ? (~i2 | i1)  : i2);
    assign want_hi[2*b+1] = en & (m_s ? (i2 & i1)   : (i2 & ~i1));
    assign want_lo[2*b+1] = en & (m_s ? (~i2 | ~i1) : i1);

    a_r5_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault[b] |=> (!hi_en[2*b] && !lo_en[2*b] && !hi_en[2*b+1] && !lo_en[2*b+1]));
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic          hi_q, lo_q;
    logic [GW-1:0] gap;
    logic          drop;

    assign drop = (hi_q && !want_hi[h]) || (lo_q && !want_lo[h]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
        gap  <= GW'(DEAD_CYCLES);
      end else if (drop) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
        gap  <= GW'(1);
      end else if (!hi_q && !lo_q) begin
        if (gap >= GW'(DEAD_CYCLES)) begin
          hi_q <= want_hi[h];
          lo_q <= want_lo[h];
        end else begin
          gap <= gap + GW'(1);
        end
      end
    end

    assign hi_en[h] = hi_q;
    assign lo_en[h] = lo_q;

    logic [GW-1:0] off_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        off_run <= GW'(DEAD_CYCLES);
      else if (hi_en[h] || lo_en[h])
        off_run <= '0;
      else if (off_run < GW'(DEAD_CYCLES))
        off_run <= off_run + GW'(1);
    end

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_en[h] && lo_en[h]));

    a_r8_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_en[h]) || $rose(lo_en[h])) |-> (off_run >= GW'(DEAD_CYCLES)));
  end

  always @(posedge clk) begin
    if (!rst_n) a_r6_sleep_off: assert (hi_en == '0 && lo_en == '0);
  end

endmodule

// File: tb/hbridge_cmd_decoder_tb.sv
`timescale 1ns/1ps
module hbridge_cmd_decoder_tb;
  localparam int DEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] cmd1 = '0, cmd2 = '0, fault = '0;
  logic [3:0] hi_en, lo_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;

  hbridge_cmd_decoder #(.BRIDGES(2), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cmd1(cmd1), .cmd2(cmd2),
    .fault(fault), .hi_en(hi_en), .lo_en(lo_en));

  task automatic check(input string req, input logic [3:0] eh, input logic [3:0] el);
    checks++;
    if (hi_en !== eh || lo_en !== el) begin
      fails++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_en, lo_en, eh, el);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R7: never both sides of one half-bridge
  always @(negedge clk) if (mon_on) begin
    checks++;
    if (|(hi_en & lo_en)) begin
      fails++;
      $display("FAIL R7: hi=%b lo=%b expected no overlap", hi_en, lo_en);
    end
  end

  task automatic t_reset;
    #1 check("R6 reset", 4'b0000, 4'b0000);
    @(negedge clk); rst_n = 1'b1; mon_on = 1;
    step(3); check("R1 coast", 4'b0000, 4'b0000);
  endtask

  task automatic t_latency_forward;
    cmd1 = 2'b01; cmd2 = 2'b00;
    step(2); check("R9 before edge 3", 4'b0000, 4'b0000);
    step(1); check("R1 R10 forward", 4'b0001, 4'b0010);
  endtask

  task automatic t_brake_gap;
    cmd2 = 2'b01;
    step(3); check("R8 brake gap start", 4'b0000, 4'b0010);
    step(DEAD-1); check("R8 brake gap end", 4'b0000, 4'b0010);
    step(1); check("R1 brake", 4'b0000, 4'b0011);
  endtask

  task automatic t_reverse;
    cmd1 = 2'b00;
    step(3); check("R8 reverse gap", 4'b0000, 4'b0001);
    step(DEAD-1); check("R8 reverse gap end", 4'b0000, 4'b0001);
    step(1); check("R1 reverse", 4'b0010, 4'b0001);
  endtask

  task automatic t_independent;
    cmd1 = 2'b10;
    step(3); check("R4 B forward A kept", 4'b0110, 4'b1001);
  endtask

  task automatic t_b_reversal;
    cmd1 = 2'b00; cmd2 = 2'b11;
    step(3); check("R8 B both off", 4'b0010, 4'b0001);
    step(DEAD-1); check("R8 B still off", 4'b0010, 4'b0001);
    step(1); check("R1 R4 B reverse", 4'b1010, 4'b0101);
  endtask

  task automatic t_phen_brake;
    mode = 1'b1; cmd2 = 2'b00;
    step(3+DEAD); check("R2 enable low brake", 4'b0000, 4'b1111);
    cmd1 = 2'b11;
    step(3); check("R2 phase ignored", 4'b0000, 4'b1111);
    step(DEAD+2); check("R2 phase ignored later", 4'b0000, 4'b1111);
  endtask

  task automatic t_phen_drive;
    cmd1 = 2'b10; cmd2 = 2'b11;
    step(3); check("R8 phen gap", 4'b0000, 4'b0110);
    step(DEAD); check("R3 A fwd B rev", 4'b1001, 4'b0110);
  endtask

  task automatic t_fault;
    fault = 2'b01;
    step(1); check("R5 fault A off", 4'b1000, 4'b0100);
    step(8); check("R5 fault held", 4'b1000, 4'b0100);
    fault = 2'b00;
    step(1); check("R10 fault release", 4'b1001, 4'b0110);
  endtask

  task automatic t_sleep;
    rst_n = 1'b0;
    #1 check("R6 sleep async", 4'b0000, 4'b0000);
    step(2); check("R6 sleep held", 4'b0000, 4'b0000);
    rst_n = 1'b1;
    step(3); check("R10 wake", 4'b1001, 4'b0110);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency_forward();
    t_brake_gap();
    t_reverse();
    t_independent();
    t_b_reversal();
    t_phen_brake();
    t_phen_drive();
    t_fault();
    t_sleep();
    mon_on = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule